// File: doc/BRIEF.md
# 6502 Bus Glue With Boot ROM

This block sits beside a 6502-family processor and turns its address and read/write lines into active-low chip selects for external RAM, an external EPROM, an expansion I/O window and an on-chip I/O window. It can also answer processor reads itself. Two of its modes do this. In one, every read gets the no-operation opcode, so the address counter can be watched running. In the other, a 16-byte table at the very top of memory replaces the EPROM, so a board can start up without a programmed EPROM.

A third mode slows the processor with its ready line. Ready is raised for one clock in every 1024, which lets a slow display follow address and data activity. All outputs are registered on the system clock. Each output therefore reflects the inputs that were sampled at the previous rising edge.

Top module: `glue_bus6502`

## Requirements
- R1: While synchronous reset is high, and in the cycle after it, all four chip selects are high, `dout_oe` is 0, `dout` is 0x00 and `rdy` is 1.
- R2: One cycle after the address is presented, `ram_cs_n` is low for addresses 0x0000 to 0xDFFF when the NOP mode is off.
- R3: One cycle after the address is presented, `iio_cs_n` is low for 0xE000 to 0xE7FF and `xio_cs_n` is low for 0xE800 to 0xEFFF, when the NOP mode is off.
- R4: `rom_cs_n` is low for 0xF000 to 0xFFFF when both the NOP mode and the internal-ROM mode are off. With the internal-ROM mode on, it is low only for 0xF000 to 0xFFEF.
- R5: At most one chip select is low in any cycle. With both special modes off, exactly one is low.
- R6: With `nop_mode` set, all chip selects are high, and every read is answered with data 0xEA whatever the address.
- R7: With `irom_mode` set and `nop_mode` clear, a read of 0xFFF0 to 0xFFFF is answered from the on-chip table indexed by address bits 3:0. All other addresses decode as in R2 to R4.
- R8: The table holds A9 55 8D 00 E0 4C F0 FF EA EA EA EA F0 FF F0 FF for indices 0 to 15. The reset vector (0xFFFC/0xFFFD) is therefore 0xFFF0.
- R9: `dout_oe` is 1 only when, in the previous cycle, `rw` was 1 (read), `phi2` was 1 and internal data was selected. Whenever `dout_oe` is 0, `dout` is 0x00.
- R10: With `throttle_en` set and `rw` held at 1, `rdy` is high for exactly one cycle in every 1024 cycles.
- R11: `rdy` is 1 one cycle after any cycle in which `throttle_en` is 0 or `rw` is 0 (write cycles are never stalled).
- R12: When `nop_mode` and `irom_mode` are both set, the NOP mode wins: the data is 0xEA even at 0xFFF0 to 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | Processor address |
| rw | input | 1 | 1 = read, 0 = write |
| phi2 | input | 1 | Processor phase-2 clock level |
| nop_mode | input | 1 | Answer all reads with the NOP opcode |
| irom_mode | input | 1 | Replace top 16 bytes of EPROM with on-chip table |
| throttle_en | input | 1 | Stretch processor cycles through the ready line |
| ram_cs_n | output | 1 | External RAM select, active low |
| rom_cs_n | output | 1 | External EPROM select, active low |
| xio_cs_n | output | 1 | Expansion I/O select, active low |
| iio_cs_n | output | 1 | On-chip I/O select, active low |
| dout | output | 8 | Read data driven onto the processor bus |
| dout_oe | output | 1 | Enable for `dout` |
| rdy | output | 1 | Processor ready |

## Verification
Every chip select, the data and its enable are due exactly one clock after the inputs that produce them. The bench changes the inputs at a falling edge and compares at the next falling edge, after one rising edge has registered the result. The ready line is also registered once, behind a free-running counter. Its checks therefore measure the spacing between high pulses and the pulse width over a long window, instead of predicting an absolute phase. Write cycles and a disabled throttle are checked one cycle after they are applied.

// File: rtl/glue_pkg.sv
package glue_pkg;
  typedef enum logic [1:0] {
    RG_RAM = 2'd0,
    RG_IIO = 2'd1,
    RG_XIO = 2'd2,
    RG_ROM = 2'd3
  } region_e;

  localparam logic [7:0] NOP_OPCODE = 8'hEA;
endpackage

// File: rtl/glue_decode.sv
module glue_decode
  import glue_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] RAM_LAST = 16'hDFFF,
  parameter logic [ADDR_W-1:0] IIO_LAST = 16'hE7FF,
  parameter logic [ADDR_W-1:0] XIO_LAST = 16'hEFFF
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region
);
  always_comb begin
    if (addr <= RAM_LAST)      region = RG_RAM;
    else if (addr <= IIO_LAST) region = RG_IIO;
    else if (addr <= XIO_LAST) region = RG_XIO;
    else                       region = RG_ROM;
  end
endmodule

// File: rtl/glue_bootrom.sv
module glue_bootrom #(
  parameter int ROM_AW = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic [ROM_AW-1:0] idx,
  output logic [DATA_W-1:0] data_q
);
  localparam int DEPTH = 1 << ROM_AW;

  logic [DATA_W-1:0] mem [DEPTH];

  // Loop at the top of memory storing a constant to on-chip I/O.
  // Vectors at indices 12..15 point back to the first entry.
  function automatic logic [DATA_W-1:0] boot_byte(input int i);
    case (i)
      0:  return DATA_W'(8'hA9);
      1:  return DATA_W'(8'h55);
      2:  return DATA_W'(8'h8D);
      3:  return DATA_W'(8'h00);
      4:  return DATA_W'(8'hE0);
      5:  return DATA_W'(8'h4C);
      6:  return DATA_W'(8'hF0);
      7:  return DATA_W'(8'hFF);
      12: return DATA_W'(8'hF0);
      13: return DATA_W'(8'hFF);
      14: return DATA_W'(8'hF0);
      15: return DATA_W'(8'hFF);
      default: return DATA_W'(8'hEA);
    endcase
  endfunction

  for (genvar g = 0; g < DEPTH; g++) begin : g_fill
    assign mem[g] = boot_byte(g);
  end

  always_ff @(posedge clk) begin
    data_q <= mem[idx];
  end
endmodule

// File: rtl/glue_throttle.sv
module glue_throttle #(
  parameter int CNT_W = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic rw,
  output logic rdy
);
  localparam logic [CNT_W-1:0] LAST = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      rdy   <= 1'b1;
    end else begin
      cnt_q <= en ? cnt_q + 1'b1 : '0;
      rdy   <= !en || !rw || (cnt_q == LAST);
    end
  end

  // R10: a ready pulse on a throttled read is one cycle wide
  p_rdy_single_r10: assert property (@(posedge clk) disable iff (rst)
    (rdy && $past(en && rw) && en && rw) |=> !rdy);

  // R11: writes and a disabled throttle never stall
  p_rdy_free_r11: assert property (@(posedge clk) disable iff (rst)
    (!en || !rw) |=> rdy);
endmodule

// File: rtl/glue_bus6502.sv
module glue_bus6502
  import glue_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int ROM_AW = 4,
  parameter int THR_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rw,
  input  logic              phi2,
  input  logic              nop_mode,
  input  logic              irom_mode,
  input  logic              throttle_en,
  output logic              ram_cs_n,
  output logic              rom_cs_n,
  output logic              xio_cs_n,
  output logic              iio_cs_n,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe,
  output logic              rdy
);
  localparam int WIN_W = ADDR_W - ROM_AW;

  region_e           region;
  logic              top_win, rom_sel, int_sel;
  logic              nop_q;
  logic [DATA_W-1:0] rom_q;

  glue_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr   (addr),
    .region (region)
  );

  glue_bootrom #(.ROM_AW(ROM_AW), .DATA_W(DATA_W)) u_rom (
    .clk    (clk),
    .idx    (addr[ROM_AW-1:0]),
    .data_q (rom_q)
  );

  glue_throttle #(.CNT_W(THR_W)) u_thr (
    .clk (clk),
    .rst (rst),
    .en  (throttle_en),
    .rw  (rw),
    .rdy (rdy)
  );

  assign top_win = (addr[ADDR_W-1:ROM_AW] == {WIN_W{1'b1}});
  assign rom_sel = irom_mode && top_win;
  assign int_sel = nop_mode || rom_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_cs_n <= 1'b1;
      rom_cs_n <= 1'b1;
      xio_cs_n <= 1'b1;
      iio_cs_n <= 1'b1;
      dout_oe  <= 1'b0;
      nop_q    <= 1'b0;
    end else begin
      ram_cs_n <= nop_mode || (region != RG_RAM);
      iio_cs_n <= nop_mode || (region != RG_IIO);
      xio_cs_n <= nop_mode || (region != RG_XIO);
      rom_cs_n <= nop_mode || rom_sel || (region != RG_ROM);
      dout_oe  <= rw && phi2 && int_sel;
      nop_q    <= nop_mode;
    end
  end

  assign dout = !dout_oe ? '0 : (nop_q ? DATA_W'(NOP_OPCODE) : rom_q);

  // R5: no two external/internal selects at once
  p_cs_exclusive_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({~ram_cs_n, ~rom_cs_n, ~xio_cs_n, ~iio_cs_n}));

  // R9: drive only after a read during phase 2
  p_oe_read_r9: assert property (@(posedge clk) disable iff (rst)
    dout_oe |-> ($past(rw) && $past(phi2)));

  // R6: NOP feed deselects every device
  p_nop_desel_r6: assert property (@(posedge clk) disable iff (rst)
    nop_mode |=> (ram_cs_n && rom_cs_n && xio_cs_n && iio_cs_n));

  // R7: on-chip table hides the EPROM in its window
  p_rom_hidden_r7: assert property (@(posedge clk) disable iff (rst)
    (irom_mode && top_win) |=> rom_cs_n);

  // R12: NOP data wins whenever it is driven
  p_nop_data_r12: assert property (@(posedge clk) disable iff (rst)
    (dout_oe && nop_q) |-> (dout == DATA_W'(NOP_OPCODE)));
endmodule

// File: tb/glue_bus6502_bench.sv
module glue_bus6502_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr = '0;
  logic        rw = 1'b1, phi2 = 1'b0;
  logic        nop_mode = 1'b0, irom_mode = 1'b0, throttle_en = 1'b0;
  logic        ram_cs_n, rom_cs_n, xio_cs_n, iio_cs_n, dout_oe, rdy;
  logic [7:0]  dout;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  glue_bus6502 u_glue_bus6502 (
    .clk(clk), .rst(rst), .addr(addr), .rw(rw), .phi2(phi2),
    .nop_mode(nop_mode), .irom_mode(irom_mode), .throttle_en(throttle_en),
    .ram_cs_n(ram_cs_n), .rom_cs_n(rom_cs_n), .xio_cs_n(xio_cs_n),
    .iio_cs_n(iio_cs_n), .dout(dout), .dout_oe(dout_oe), .rdy(rdy)
  );

  function automatic logic [7:0] table_byte(input logic [3:0] i);
    logic [7:0] t [16] = '{8'hA9, 8'h55, 8'h8D, 8'h00, 8'hE0, 8'h4C, 8'hF0, 8'hFF,
                           8'hEA, 8'hEA, 8'hEA, 8'hEA, 8'hF0, 8'hFF, 8'hF0, 8'hFF};
    return t[i];
  endfunction

  // Expected {ram,rom,xio,iio} active-low selects
  function automatic logic [3:0] exp_cs(input logic [15:0] a, input logic nm, input logic im);
    logic [3:0] c = 4'b1111;
    if (!nm) begin
      if (a <= 16'hDFFF)      c[3] = 1'b0;
      else if (a <= 16'hE7FF) c[0] = 1'b0;
      else if (a <= 16'hEFFF) c[1] = 1'b0;
      else if (!(im && a >= 16'hFFF0)) c[2] = 1'b0;
    end
    return c;
  endfunction

  function automatic logic [8:0] exp_data(input logic [15:0] a, input logic r, input logic p,
                                          input logic nm, input logic im);
    if (r && p && nm) return {1'b1, 8'hEA};
    if (r && p && im && a >= 16'hFFF0) return {1'b1, table_byte(a[3:0])};
    return 9'h000;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic access(input string req, input logic [15:0] a, input logic r, input logic p,
                        input logic nm, input logic im);
    @(negedge clk);
    addr = a; rw = r; phi2 = p; nop_mode = nm; irom_mode = im;
    @(negedge clk);
    check(req, {28'd0, ram_cs_n, rom_cs_n, xio_cs_n, iio_cs_n}, {28'd0, exp_cs(a, nm, im)});
    check(req, {23'd0, dout_oe, dout}, {23'd0, exp_data(a, r, p, nm, im)});
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int last_rise, highs, gap_bad, wide;
    logic prev;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {28'd0, ram_cs_n, rom_cs_n, xio_cs_n, iio_cs_n}, 32'hF);
    check("R1", {22'd0, rdy, dout_oe, dout}, {22'd0, 1'b1, 1'b0, 8'h00});
    @(negedge clk); rst = 1'b0;
    check("R1", {31'd0, dout_oe}, 32'd0);

    // Directed boundaries
    access("R2", 16'h0000, 1, 1, 0, 0);
    access("R2", 16'hDFFF, 1, 1, 0, 0);
    access("R3", 16'hE000, 1, 1, 0, 0);
    access("R3", 16'hE7FF, 0, 1, 0, 0);
    access("R3", 16'hE800, 1, 1, 0, 0);
    access("R3", 16'hEFFF, 1, 1, 0, 0);
    access("R4", 16'hF000, 1, 1, 0, 0);
    access("R4", 16'hFFFF, 1, 1, 0, 0);
    access("R4", 16'hFFEF, 1, 1, 0, 1);
    access("R6", 16'h1234, 1, 1, 1, 0);
    access("R6", 16'hF800, 1, 1, 1, 0);
    access("R12", 16'hFFF3, 1, 1, 1, 1);
    access("R9", 16'hFFF5, 0, 1, 0, 1);
    access("R9", 16'hFFF5, 1, 0, 0, 1);
    access("R9", 16'h4000, 1, 1, 1, 0);
    for (int i = 0; i < 16; i++) access("R8", 16'hFFF0 + 16'(i), 1, 1, 0, 1);
    access("R7", 16'h8000, 1, 1, 0, 1);

    // Constrained random mix
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      int sel = $urandom % 4;
      a = (sel == 0) ? (16'hFFF0 | 16'($urandom % 16)) :
          (sel == 1) ? (16'hE000 + 16'($urandom % 16'h2000)) : 16'($urandom);
      access("R5", a, 1'($urandom), 1'($urandom), ($urandom % 5) == 0, 1'($urandom));
    end

    // R10 throttle spacing
    @(negedge clk);
    addr = 16'h0200; rw = 1'b1; phi2 = 1'b1; nop_mode = 1'b0; irom_mode = 1'b0;
    throttle_en = 1'b1;
    @(negedge clk);
    highs = 0; gap_bad = 0; wide = 0; last_rise = -1; prev = 1'b0;
    for (int c = 0; c < 3200; c++) begin
      @(negedge clk);
      if (c >= 2) begin
        if (rdy && prev) wide++;
        if (rdy && !prev) begin
          if (last_rise >= 0 && c - last_rise != 1024) gap_bad++;
          last_rise = c;
          highs++;
        end
      end
      prev = rdy;
    end
    check("R10 pulses", highs, 3);
    check("R10 spacing", gap_bad, 0);
    check("R10 width", wide, 0);

    // R11 writes and disabled throttle
    @(negedge clk); rw = 1'b0;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      check("R11 write", {31'd0, rdy}, 32'd1);
    end
    rw = 1'b1; throttle_en = 1'b0;
    @(negedge clk);
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      check("R11 off", {31'd0, rdy}, 32'd1);
    end

    // R1 reset again mid-run
    nop_mode = 1'b1; rst = 1'b1;
    @(negedge clk);
    check("R1 rerun", {27'd0, ram_cs_n, rom_cs_n, xio_cs_n, iio_cs_n, dout_oe}, 32'h1E);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule